// File: doc/BRIEF.md
# Shared-Multiple Transposed FIR Filter

This block is a streaming finite impulse response filter built in transposed direct form. Each accepted input sample is multiplied by every coefficient in the same cycle. The products are then added into a chain of partial-sum registers, and the head of that chain is the filter output. The coefficients are fixed when the design is elaborated. The default set is a symmetric 10-tap low-pass response whose taps sum to unity gain in Q15.

The filter has no general multipliers. A single bank turns the current sample into its eight odd multiples, from 1x to 15x, using only shifts and adds. Every tap reads from that one bank. Each tap splits the magnitude of its coefficient into 4-bit digits. For each digit it takes the bank entry that matches the digit's odd part and shifts it left by the digit's count of trailing zeros. It then weights the result by 16 to the power of the digit's position and sums across the digits. A tap with a negative coefficient negates its product. The output keeps full precision.

Top module: `csf_fir_top`

## Requirements
- R1: A synchronous reset clears every partial-sum register and the output valid flag. After reset, `out_valid` is 0 and `out_data` is 0, and samples accepted before the reset have no influence on later outputs.
- R2: A sample is accepted on a rising edge where `in_valid` is 1. Its output appears with `out_valid` high exactly two rising edges after acceptance. There is exactly one output per accepted sample.
- R3: The shared bank holds 1x, 3x, 5x, 7x, 9x, 11x, 13x and 15x of the most recently accepted sample, in that order, and is exact for every 16-bit signed input.
- R4: For the n-th accepted sample since reset, `out_data` equals the sum over taps i of c[i]·x[n−i], where c[0] is the first entry of the coefficient parameter and samples before reset count as zero.
- R5: Every digit value 0 to 15 gives an exact product. Zero digits contribute nothing. Even digits are formed by shifting the odd multiple that remains after removing their factors of two.
- R6: Negative coefficients, including the most negative 16-bit value −32768, give exact products.
- R7: While `in_valid` is 0, the value on `in_sample` is ignored, `out_valid` stays 0 one cycle later, and `out_data` and the partial sums hold their values.
- R8: Full-scale inputs (+32767 and −32768, alternating or repeated) produce exact results with no overflow. The output is DATA_W+COEF_W+clog2(NTAPS) bits wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe; the sample is accepted when high |
| in_sample | input | DATA_W (16) | Signed input sample |
| out_valid | output | 1 | High for one cycle per filtered result |
| out_data | output | DATA_W+COEF_W+clog2(NTAPS) (36) | Signed full-precision filter output |

## Verification
The input is registered into the bank stage on the edge that accepts it, and the chain head is registered on the following edge. Each result is therefore due two rising edges after its sample is accepted. The driver stamps every expected value with the edge count at which its sample was presented. The monitor samples on the falling edge, and for each valid output it checks both the value, against a plain-multiplication convolution, and that exactly two edges have passed since the stamp. On falling edges without a valid output, the monitor checks that the held output is unchanged while random values sit on the ignored sample input.

// File: rtl/csf_pkg.sv
package csf_pkg;

    localparam int DIGIT_W   = 4;
    localparam int ODD_COUNT = 8;

    // number of trailing zero bits in a radix-16 digit (zero digit -> 0)
    function automatic logic [1:0] tz4(input logic [DIGIT_W-1:0] d);
        logic [1:0] n;
        if (d[0])      n = 2'd0;
        else if (d[1]) n = 2'd1;
        else if (d[2]) n = 2'd2;
        else if (d[3]) n = 2'd3;
        else           n = 2'd0;
        return n;
    endfunction

    // bank slot of the odd part of a digit: odd value m sits at (m-1)/2
    function automatic logic [2:0] odd_slot(input logic [DIGIT_W-1:0] d);
        logic [DIGIT_W-1:0] oddpart;
        oddpart = d >> tz4(d);
        return oddpart[3:1];
    endfunction

endpackage

// File: rtl/csf_odd_bank.sv
module csf_odd_bank import csf_pkg::*; #(
    parameter int DATA_W = 16,
    parameter int MULT_W = DATA_W + DIGIT_W
) (
    input  logic [DATA_W-1:0]                 sample,
    output logic [ODD_COUNT-1:0][MULT_W-1:0]  odd
);

    logic [MULT_W-1:0] x1;
    logic [MULT_W-1:0] x2;
    logic [MULT_W-1:0] x4;
    logic [MULT_W-1:0] x8;
    logic [MULT_W-1:0] x16;

    always_comb begin
        x1  = MULT_W'(signed'(sample));
        x2  = x1 << 1;
        x4  = x1 << 2;
        x8  = x1 << 3;
        x16 = x1 << 4;
        odd[0] = x1;
        odd[1] = x2 + x1;
        odd[2] = x4 + x1;
        odd[3] = x8 - x1;
        odd[4] = x8 + x1;
        odd[5] = x8 + x2 + x1;
        odd[6] = x8 + x4 + x1;
        odd[7] = x16 - x1;
    end

endmodule

// File: rtl/csf_digit_term.sv
module csf_digit_term import csf_pkg::*; #(
    parameter int MULT_W = 20,
    parameter int TERM_W = MULT_W + DIGIT_W - 1
) (
    input  logic [DIGIT_W-1:0]                digit,
    input  logic [ODD_COUNT-1:0][MULT_W-1:0]  odd,
    output logic [TERM_W-1:0]                 term
);

    logic [MULT_W-1:0] picked;
    logic [TERM_W-1:0] widened;

    always_comb begin
        picked  = odd[odd_slot(digit)];
        widened = TERM_W'(signed'(picked));
        if (digit == '0) begin
            term = '0;
        end else begin
            term = widened << tz4(digit);
        end
    end

endmodule

// File: rtl/csf_tap_product.sv
module csf_tap_product import csf_pkg::*; #(
    parameter int DATA_W = 16,
    parameter int COEF_W = 16,
    parameter int MULT_W = DATA_W + DIGIT_W,
    parameter int PROD_W = DATA_W + COEF_W,
    parameter logic [COEF_W-1:0] COEF = '0
) (
    input  logic [ODD_COUNT-1:0][MULT_W-1:0]  odd,
    output logic [PROD_W-1:0]                 prod
);

    localparam int NDIG   = COEF_W / DIGIT_W;
    localparam int TERM_W = MULT_W + DIGIT_W - 1;
    localparam logic NEG  = COEF[COEF_W-1];
    localparam logic [COEF_W-1:0] MAG = NEG ? COEF_W'(~COEF + 1'b1) : COEF;

    logic [NDIG-1:0][TERM_W-1:0] term;
    logic [PROD_W-1:0]           mag_sum;

    for (genvar j = 0; j < NDIG; j++) begin : g_digit
        csf_digit_term #(
            .MULT_W (MULT_W),
            .TERM_W (TERM_W)
        ) u_digit (
            .digit (MAG[j*DIGIT_W +: DIGIT_W]),
            .odd   (odd),
            .term  (term[j])
        );
    end

    always_comb begin
        mag_sum = '0;
        for (int j = 0; j < NDIG; j++) begin
            mag_sum = mag_sum + (PROD_W'(signed'(term[j])) << (j * DIGIT_W));
        end
        prod = NEG ? (~mag_sum + 1'b1) : mag_sum;
    end

endmodule

// File: rtl/csf_fir_top.sv
module csf_fir_top import csf_pkg::*; #(
    parameter int DATA_W = 16,
    parameter int COEF_W = 16,
    parameter int NTAPS  = 10,
    parameter logic signed [COEF_W-1:0] COEFS [NTAPS] = '{
        -16'sd512, -16'sd320, 16'sd1664, 16'sd5760, 16'sd9792,
        16'sd9792, 16'sd5760, 16'sd1664, -16'sd320, -16'sd512
    }
) (
    input  logic                                       clk,
    input  logic                                       rst,
    input  logic                                       in_valid,
    input  logic signed [DATA_W-1:0]                   in_sample,
    output logic                                       out_valid,
    output logic signed [DATA_W+COEF_W+$clog2(NTAPS)-1:0] out_data
);

    localparam int MULT_W = DATA_W + DIGIT_W;
    localparam int PROD_W = DATA_W + COEF_W;
    localparam int ACC_W  = PROD_W + $clog2(NTAPS);

    typedef struct packed {
        logic                          vld;
        logic [DATA_W-1:0]             smp;
        logic [NTAPS-1:0][ACC_W-1:0]   chain;
        logic                          ovld;
    } state_t;

    state_t st_d;
    state_t st_q;

    logic [ODD_COUNT-1:0][MULT_W-1:0] bank;
    logic [NTAPS-1:0][PROD_W-1:0]     prod;

    csf_odd_bank #(
        .DATA_W (DATA_W),
        .MULT_W (MULT_W)
    ) u_bank (
        .sample (st_q.smp),
        .odd    (bank)
    );

    for (genvar t = 0; t < NTAPS; t++) begin : g_tap
        csf_tap_product #(
            .DATA_W (DATA_W),
            .COEF_W (COEF_W),
            .MULT_W (MULT_W),
            .PROD_W (PROD_W),
            .COEF   (COEFS[t])
        ) u_tap (
            .odd  (bank),
            .prod (prod[t])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.vld  = in_valid;
        st_d.ovld = st_q.vld;
        if (in_valid) begin
            st_d.smp = in_sample;
        end
        if (st_q.vld) begin
            for (int i = 0; i < NTAPS; i++) begin
                if (i == NTAPS - 1) begin
                    st_d.chain[i] = ACC_W'(signed'(prod[i]));
                end else begin
                    st_d.chain[i] = ACC_W'(signed'(prod[i])) + st_q.chain[i+1];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.ovld;
    assign out_data  = st_q.chain[0];

endmodule

// File: rtl/csf_fir_chk.sv
module csf_fir_chk #(
    parameter int DATA_W = 16,
    parameter int MULT_W = 20,
    parameter int ACC_W  = 36,
    parameter int ODD_N  = 8
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          in_valid,
    input logic                          vld_q,
    input logic                          out_valid,
    input logic [DATA_W-1:0]             smp_q,
    input logic [ODD_N-1:0][MULT_W-1:0]  bank,
    input logic [ACC_W-1:0]              out_data
);

    // R1: reset leaves the output idle and zero
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && out_data == '0));

    // R2: an accepted sample enters the bank stage on the next edge
    a_r2_accept: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> vld_q);

    // R2: the bank stage produces an output one edge later
    a_r2_output_follows: assert property (@(posedge clk) disable iff (rst)
        vld_q |=> out_valid);

    // R7: no new sample, no output strobe
    a_r7_idle_no_output: assert property (@(posedge clk) disable iff (rst)
        !vld_q |=> !out_valid);

    // R7: no new sample, output value held
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !vld_q |=> $stable(out_data));

    // R3: each bank slot carries the matching odd multiple
    for (genvar k = 0; k < ODD_N; k++) begin : g_bank
        a_r3_bank_odd_multiple: assert property (@(posedge clk) disable iff (rst)
            int'(signed'(bank[k])) == int'(signed'(smp_q)) * (2 * k + 1));
    end

endmodule

bind csf_fir_top csf_fir_chk #(
    .DATA_W (DATA_W),
    .MULT_W (MULT_W),
    .ACC_W  (ACC_W),
    .ODD_N  (ODD_COUNT)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .vld_q     (st_q.vld),
    .out_valid (out_valid),
    .smp_q     (st_q.smp),
    .bank      (bank),
    .out_data  (out_data)
);

// File: tb/test_csf_fir_top.sv
module test_csf_fir_top;

    localparam int N1 = 10;
    localparam int N2 = 5;
    localparam int W1 = 16 + 16 + $clog2(N1);
    localparam int W2 = 16 + 16 + $clog2(N2);

    localparam logic signed [15:0] C1 [N1] = '{
        -16'sd512, -16'sd320, 16'sd1664, 16'sd5760, 16'sd9792,
        16'sd9792, 16'sd5760, 16'sd1664, -16'sd320, -16'sd512
    };
    // digits 0,1,2,9 / 4,5,6,7 / 7,F,E,D / neg 3,C,B,A / most negative
    localparam logic signed [15:0] C2 [N2] = '{
        16'sh0129, 16'sh4567, 16'sh7FED, -16'sh3CBA, 16'sh8000
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic signed [15:0] in_sample = '0;
    logic out_valid1, out_valid2;
    logic signed [W1-1:0] out_data1;
    logic signed [W2-1:0] out_data2;

    always #2 clk = ~clk;

    csf_fir_top i_csf_fir_top (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(out_valid1), .out_data(out_data1)
    );

    csf_fir_top #(.NTAPS(N2), .COEFS(C2)) i_csf_fir_top_digits (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(out_valid2), .out_data(out_data2)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit done    = 0;
    string ptag = "R4";

    longint hist[$];
    longint exp1[$], exp2[$];
    int     stp1[$], stp2[$];
    string  tag1[$], tag2[$];
    longint last1 = 0, last2 = 0;
    logic [15:0] lfsr = 16'hACE1;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("[TB] FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic send(input logic signed [15:0] x);
        longint e1, e2;
        @(negedge clk);
        in_valid  = 1'b1;
        in_sample = x;
        hist.push_front(longint'(x));
        e1 = 0;
        e2 = 0;
        for (int i = 0; i < N1 && i < hist.size(); i++) e1 += longint'(C1[i]) * hist[i];
        for (int i = 0; i < N2 && i < hist.size(); i++) e2 += longint'(C2[i]) * hist[i];
        exp1.push_back(e1); stp1.push_back(cyc); tag1.push_back(ptag);
        exp2.push_back(e2); stp2.push_back(cyc); tag2.push_back(ptag);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid  = 1'b0;
            in_sample = 16'($urandom);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        hist.delete();
        last1 = 0;
        last2 = 0;
        rst = 1'b0;
        @(negedge clk);
        check(out_valid1 == 1'b0 && out_data1 == '0, "R1 reset state tap10", longint'(out_data1), 0);
        check(out_valid2 == 1'b0 && out_data2 == '0, "R1 reset state tap5", longint'(out_data2), 0);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (out_valid1) begin
                if (exp1.size() == 0) begin
                    check(0, "R2 unexpected output tap10", longint'(out_data1), 0);
                end else begin
                    automatic longint e = exp1.pop_front();
                    automatic int     s = stp1.pop_front();
                    automatic string  t = tag1.pop_front();
                    check(longint'(out_data1) == e, {t, " value tap10"}, longint'(out_data1), e);
                    check(cyc - s == 2, "R2 latency tap10", longint'(cyc - s), 2);
                end
                last1 = longint'(out_data1);
            end else begin
                check(longint'(out_data1) == last1, "R7 hold tap10", longint'(out_data1), last1);
            end
            if (out_valid2) begin
                if (exp2.size() == 0) begin
                    check(0, "R2 unexpected output tap5", longint'(out_data2), 0);
                end else begin
                    automatic longint e = exp2.pop_front();
                    automatic int     s = stp2.pop_front();
                    automatic string  t = tag2.pop_front();
                    check(longint'(out_data2) == e, {t, " value tap5"}, longint'(out_data2), e);
                    check(cyc - s == 2, "R2 latency tap5", longint'(cyc - s), 2);
                end
                last2 = longint'(out_data2);
            end else begin
                check(longint'(out_data2) == last2, "R7 hold tap5", longint'(out_data2), last2);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("[TB] FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();

        // R5: unit impulse exposes every coefficient digit
        ptag = "R5";
        send(16'sd1);
        for (int k = 0; k < 11; k++) send(16'sd0);
        idle(4);

        // R3: impulses of odd and even values walk the bank
        ptag = "R3";
        send(16'sd7);
        send(-16'sd9);
        send(16'sd1234);
        for (int k = 0; k < 10; k++) send(16'sd0);
        idle(3);

        // R6: most negative sample into negative coefficients
        ptag = "R6";
        send(-16'sd32768);
        for (int k = 0; k < 10; k++) send(16'sd0);
        idle(3);

        // R8: full-scale patterns
        ptag = "R8";
        for (int k = 0; k < 12; k++) send(16'sd32767);
        for (int k = 0; k < 12; k++) send(-16'sd32768);
        for (int k = 0; k < 16; k++) send(k[0] ? -16'sd32768 : 16'sd32767);
        idle(3);

        // R4 and R7: pseudo-random samples with gaps
        ptag = "R4";
        for (int k = 0; k < 300; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            send(signed'(lfsr));
            if (lfsr[2:0] == 3'd5) idle(int'(lfsr[5:4]) + 1);
        end
        idle(4);

        // R1: reset with a loaded chain, then impulse must see a clean history
        do_reset();
        ptag = "R1";
        send(16'sd3);
        for (int k = 0; k < 10; k++) send(16'sd0);
        idle(5);

        check(exp1.size() == 0, "R2 drained tap10", longint'(exp1.size()), 0);
        check(exp2.size() == 0, "R2 drained tap5", longint'(exp2.size()), 0);

        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule